// File: doc/BRIEF.md
# Two-Wire Sigma-Delta Result Reader

This block is the host side of a two-wire link to a sigma-delta converter. The link has a clock that the host drives and a single line that the converter drives. That line first acts as a ready flag and then carries the data bits. The reader waits until the line has been seen high and then low. It then clocks in a 24-bit frame, made of a 16-bit offset-binary result followed by an 8-bit status byte. It checks the integrity pattern, the device identity and the out-of-range flag in that byte. It presents the result in raw form and in two's-complement form, with a one-cycle valid strobe.

The reader also owns the converter's active-low power-down/reset pin. It stretches any reset request so the pin stays low for a minimum number of cycles. While the pin is low, the reader ignores the data line. After release, it rearms the ready detection. A deadline counter starts when ready is detected and aborts a read that is still running when the next conversion would land. A start-up watchdog flags a converter that never becomes ready after the reset pin is released.

Top module: `adc_frame_reader`

## Requirements
- R1: While rst_ni is low and on the first cycles after its release, pdrst_no is 0, sclk_o is 1, and valid_o, overrun_o and timeout_o are 0.
- R2: pdrst_no goes low in the cycle after pd_req_i is sampled high and stays low while pd_req_i is high. After pd_req_i drops, or after rst_ni is released, it stays low for at least PD_LOW_CYC further clock cycles.
- R3: sclk_o idles high. A frame starts only after the synchronized data line has been seen high and then low, with pdrst_no high. A line that stays low after a frame starts nothing.
- R4: A frame is exactly 24 sclk_o rising edges. The data line is sampled on each rising edge, MSB first, and the first 16 bits form result_o.
- R5: result_signed_o equals result_o with bit 15 inverted (0x8000 reads as 0, 0x0000 as -32768, 0xFFFF as 32767).
- R6: valid_o pulses for exactly one cycle per completed frame. status_o holds the last 8 bits received, with bit 7 as the ready bit, bit 6 as the fixed zero, bit 5 as the range error, bits 4:3 as the ID and bits 2:0 as the pattern.
- R7: xfer_err_o is 1 when status bits 2:0 differ from 101, or bit 7 or bit 6 is 1.
- R8: id_err_o is 1 when status bits 4:3 differ from 01.
- R9: range_err_o equals status bit 5.
- R10: If a frame is not complete CONV_CYC cycles after ready was detected, overrun_o pulses once, valid_o does not fire, and sclk_o returns high.
- R11: timeout_o sets when no ready has been detected TMO_CYC cycles after pdrst_no goes high, and clears when the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Request to power down and reset the converter |
| sdata_i | input | 1 | Shared ready/data line from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| pdrst_no | output | 1 | Active-low power-down/reset pin of the converter |
| result_o | output | RES_W | Raw offset-binary result |
| result_signed_o | output | RES_W | Two's-complement result |
| status_o | output | 8 | Received status byte |
| valid_o | output | 1 | One-cycle strobe when a frame completes |
| range_err_o | output | 1 | Input out of range for the last frame |
| xfer_err_o | output | 1 | Pattern or fixed-bit mismatch for the last frame |
| id_err_o | output | 1 | Wrong device identity for the last frame |
| overrun_o | output | 1 | One-cycle strobe when a read is aborted at the deadline |
| timeout_o | output | 1 | No ready seen within the start-up window |

## Verification
The hardest case to reach is the overrun abort. A correct host clocks a full frame well inside one conversion period, so the deadline never expires under normal stimulus. The bench therefore instantiates a second reader whose conversion window is shorter than one frame's clocking time, and holds its data line low to force the abort. The stale-low ready line after a frame is also hard to reach, because a normal frame ends with the pattern bit high. The bench sends a frame whose last bit is 0 and keeps the line low afterwards, then watches that no clock edges follow.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {ST_PD, ST_ARM, ST_WAIT, ST_SHIFT} rd_state_e;

  typedef struct packed {
    logic       rdy_n;
    logic       zero;
    logic       err;
    logic [1:0] id;
    logic [2:0] pat;
  } stat_t;

  localparam logic [2:0] PAT_OK = 3'b101;
  localparam logic [1:0] DEV_ID = 2'b01;
endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign rise_o = en_i && wrap && !sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_pdctl.sv
module adc_rd_pdctl #(
  parameter int unsigned LOW_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_req_i,
  output logic pdrst_no
);
  localparam int unsigned CW = $clog2(LOW_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          pd_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pd_n_q <= 1'b0;
    end else if (pd_req_i) begin
      cnt_q  <= '0;
      pd_n_q <= 1'b0;
    end else if (cnt_q == CW'(LOW_CYC - 1)) begin
      pd_n_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pdrst_no = pd_n_q;

  // checker: consecutive low cycles seen on the pin
  logic [CW-1:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run_q <= '0;
    else if (pd_n_q) low_run_q <= '0;
    else if (low_run_q != CW'(LOW_CYC)) low_run_q <= low_run_q + 1'b1;
  end

  // R2
  pd_min_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdrst_no) |-> low_run_q >= CW'(LOW_CYC))
    else $error("pdrst released too early");
endmodule

// File: rtl/adc_rd_status.sv
module adc_rd_status
  import adc_rd_pkg::*;
(
  input  stat_t stat_i,
  output logic  range_err_o,
  output logic  xfer_err_o,
  output logic  id_err_o
);
  assign range_err_o = stat_i.err;
  assign xfer_err_o  = stat_i.rdy_n | stat_i.zero | (stat_i.pat != PAT_OK);
  assign id_err_o    = (stat_i.id != DEV_ID);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned RES_W      = 16,
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned PD_LOW_CYC = 10,
  parameter int unsigned CONV_CYC   = 400000,
  parameter int unsigned TMO_CYC    = 1000000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pd_req_i,
  input  logic                    sdata_i,
  output logic                    sclk_o,
  output logic                    pdrst_no,
  output logic [RES_W-1:0]        result_o,
  output logic signed [RES_W-1:0] result_signed_o,
  output logic [7:0]              status_o,
  output logic                    valid_o,
  output logic                    range_err_o,
  output logic                    xfer_err_o,
  output logic                    id_err_o,
  output logic                    overrun_o,
  output logic                    timeout_o
);
  localparam int unsigned STAT_W  = $bits(stat_t);
  localparam int unsigned FRAME_W = RES_W + STAT_W;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam int unsigned DL_W    = $clog2(CONV_CYC + 1);
  localparam int unsigned TM_W    = $clog2(TMO_CYC + 1);

  rd_state_e          state_q;
  logic [1:0]         sync_q;
  logic               data_s;
  logic               rise;
  logic               go_shift;
  logic [FRAME_W-2:0] sh_q;
  logic [FRAME_W-1:0] frame_w;
  logic [BIT_W-1:0]   bit_q;
  logic [DL_W-1:0]    dl_q;
  logic [RES_W-1:0]   res_q;
  logic [STAT_W-1:0]  stat_q;
  logic               valid_q, ovr_q, rerr_q, xerr_q, iderr_q;
  logic               rerr_w, xerr_w, iderr_w;
  logic [TM_W-1:0]    tcnt_q;
  logic               tarm_q, tmo_q;

  // two-flop synchronizer on the shared line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], sdata_i};
  end
  assign data_s = sync_q[1];

  adc_rd_pdctl #(.LOW_CYC(PD_LOW_CYC)) u_pdctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_req_i (pd_req_i),
    .pdrst_no (pdrst_no)
  );

  adc_rd_sclk #(.HALF(CLK_DIV)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SHIFT),
    .sclk_o (sclk_o),
    .rise_o (rise)
  );

  assign frame_w = {sh_q, data_s};

  adc_rd_status u_status (
    .stat_i      (stat_t'(frame_w[STAT_W-1:0])),
    .range_err_o (rerr_w),
    .xfer_err_o  (xerr_w),
    .id_err_o    (iderr_w)
  );

  assign go_shift = (state_q == ST_WAIT) && pdrst_no && !data_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PD;
      sh_q    <= '0;
      bit_q   <= '0;
      dl_q    <= '0;
      res_q   <= '0;
      stat_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      rerr_q  <= 1'b0;
      xerr_q  <= 1'b0;
      iderr_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      unique case (state_q)
        ST_PD:   if (pdrst_no) state_q <= ST_ARM;
        ST_ARM: begin
          if (!pdrst_no)   state_q <= ST_PD;
          else if (data_s) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!pdrst_no) state_q <= ST_PD;
          else if (go_shift) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
            dl_q    <= '0;
          end
        end
        ST_SHIFT: begin
          if (!pdrst_no) begin
            state_q <= ST_PD;
          end else if (dl_q == DL_W'(CONV_CYC - 1)) begin
            ovr_q   <= 1'b1;
            state_q <= ST_ARM;
          end else begin
            dl_q <= dl_q + 1'b1;
            if (rise) begin
              sh_q  <= frame_w[FRAME_W-2:0];
              bit_q <= bit_q + 1'b1;
              if (bit_q == BIT_W'(FRAME_W - 1)) begin
                res_q   <= frame_w[FRAME_W-1:STAT_W];
                stat_q  <= frame_w[STAT_W-1:0];
                rerr_q  <= rerr_w;
                xerr_q  <= xerr_w;
                iderr_q <= iderr_w;
                valid_q <= 1'b1;
                state_q <= ST_ARM;
              end
            end
          end
        end
        default: state_q <= ST_PD;
      endcase
    end
  end

  // start-up watchdog, armed by each reset-pin release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tarm_q <= 1'b1;
      tcnt_q <= '0;
      tmo_q  <= 1'b0;
    end else if (state_q == ST_PD) begin
      tarm_q <= 1'b1;
      tcnt_q <= '0;
      tmo_q  <= 1'b0;
    end else if (go_shift) begin
      tarm_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (tarm_q && !tmo_q) begin
      if (tcnt_q == TM_W'(TMO_CYC - 1)) tmo_q <= 1'b1;
      else tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign result_o        = res_q;
  assign result_signed_o = {~res_q[RES_W-1], res_q[RES_W-2:0]};
  assign status_o        = stat_q;
  assign valid_o         = valid_q;
  assign range_err_o     = rerr_q;
  assign xfer_err_o      = xerr_q;
  assign id_err_o        = iderr_q;
  assign overrun_o       = ovr_q;
  assign timeout_o       = tmo_q;

  // R2
  pd_forces_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdrst_no |=> state_q == ST_PD)
    else $error("reader active while converter held in reset");

  // R3
  sclk_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SHIFT) && ($past(state_q) != ST_SHIFT) |-> sclk_o)
    else $error("sclk low outside a frame");

  // R6
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o)
    else $error("valid longer than one cycle");

  // R10
  ovr_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && overrun_o))
    else $error("overrun and valid together");

  // R11
  tmo_not_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> state_q != ST_SHIFT)
    else $error("timeout still set during a frame");
endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int PDL  = 6;
  localparam int CONV = 300;
  localparam int TMO  = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0;
  logic sd = 1'b1;
  logic sclk, pdrst_n, valid, rerr, xerr, iderr, ovr, tmo;
  logic [15:0] res;
  logic signed [15:0] res_s;
  logic [7:0] stat;

  logic sd2 = 1'b1;
  logic sclk2, pdrst2_n, valid2, ovr2, tmo2, rerr2, xerr2, iderr2;
  logic [15:0] res2;
  logic signed [15:0] res2_s;
  logic [7:0] stat2;

  int n_chk = 0, n_fail = 0, rise_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge sclk) rise_cnt++;

  adc_frame_reader #(.CLK_DIV(DIV), .PD_LOW_CYC(PDL), .CONV_CYC(CONV), .TMO_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .sdata_i(sd),
    .sclk_o(sclk), .pdrst_no(pdrst_n), .result_o(res), .result_signed_o(res_s),
    .status_o(stat), .valid_o(valid), .range_err_o(rerr), .xfer_err_o(xerr),
    .id_err_o(iderr), .overrun_o(ovr), .timeout_o(tmo));

  adc_frame_reader #(.CLK_DIV(DIV), .PD_LOW_CYC(PDL), .CONV_CYC(100), .TMO_CYC(1000)) dut_ovr_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(1'b0), .sdata_i(sd2),
    .sclk_o(sclk2), .pdrst_no(pdrst2_n), .result_o(res2), .result_signed_o(res2_s),
    .status_o(stat2), .valid_o(valid2), .range_err_o(rerr2), .xfer_err_o(xerr2),
    .id_err_o(iderr2), .overrun_o(ovr2), .timeout_o(tmo2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // converter model: ready low, shift MSB first on sclk falling edges
  task automatic send_frame(input logic [23:0] w, input bit hold_low);
    sd = 1'b1;
    wait_clks(4);
    sd = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      @(negedge sclk);
      sd = w[i];
    end
    @(posedge sclk);
    #1 sd = hold_low ? 1'b0 : 1'b1;
  endtask

  task automatic run_frame(input logic [15:0] r, input logic [7:0] s, input bit hold_low);
    int  r0;
    bit  got;
    r0 = rise_cnt;
    got = 0;
    send_frame({r, s}, hold_low);
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (valid) got = 1;
    end
    chk(got, "R6 valid pulse", int'(got), 1);
    chk(rise_cnt - r0 == 24, "R4 rising edges", rise_cnt - r0, 24);
    chk(res == r, "R4 result", int'(res), int'(r));
    chk(res_s == $signed(r ^ 16'h8000), "R5 signed result", int'(res_s), int'(r ^ 16'h8000));
    chk(stat == s, "R6 status", int'(stat), int'(s));
    chk(xerr == ((s[2:0] != 3'b101) || s[7] || s[6]), "R7 xfer err", int'(xerr),
        int'((s[2:0] != 3'b101) || s[7] || s[6]));
    chk(iderr == (s[4:3] != 2'b01), "R8 id err", int'(iderr), int'(s[4:3] != 2'b01));
    chk(rerr == s[5], "R9 range err", int'(rerr), int'(s[5]));
    @(negedge clk);
    chk(!valid, "R6 valid single cycle", int'(valid), 0);
  endtask

  initial begin
    int n;
    bit saw_ovr, saw_val;
    wait_clks(3);
    chk(!pdrst_n && sclk && !valid && !ovr && !tmo, "R1 reset state",
        {pdrst_n, sclk, valid, ovr, tmo}, 5'b01000);
    rst_n = 1'b1;
    n = 0;
    while (!pdrst_n) begin @(negedge clk); n++; end
    chk(n >= PDL, "R2 low after reset", n, PDL);
    chk(sclk && !valid, "R1 idle after reset", {sclk, valid}, 2'b10);

    wait_clks(50);
    chk(!tmo, "R11 no early timeout", int'(tmo), 0);
    wait_clks(TMO);
    chk(tmo, "R11 timeout set", int'(tmo), 1);
    chk(sclk, "R3 sclk idle while waiting", int'(sclk), 1);

    run_frame(16'h8000, 8'h0D, 0);
    chk(!tmo, "R11 timeout cleared", int'(tmo), 0);

    for (int k = 0; k < 16; k++) run_frame(16'(k * 16'h1111), 8'h0D, 0);
    for (int b = 0; b < 8; b++) run_frame(16'h8000 ^ 16'(1 << b), 8'h0D ^ 8'(1 << b), 0);

    // R3: line stays low after a frame, no new frame may start
    run_frame(16'h1234, 8'h0C, 1);
    n = rise_cnt;
    wait_clks(60);
    chk(rise_cnt == n && sclk, "R3 stale low ignored", rise_cnt - n, 0);
    run_frame(16'hFFFF, 8'h0D, 0);

    // R2: single-cycle request still yields minimum low time
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    n = 0;
    while (!pdrst_n) begin @(negedge clk); n++; end
    chk(n >= PDL, "R2 stretched request", n, PDL);
    pd_req = 1'b1;
    wait_clks(20);
    chk(!pdrst_n, "R2 held while requested", int'(pdrst_n), 0);
    pd_req = 1'b0;
    n = 0;
    while (!pdrst_n) begin @(negedge clk); n++; end
    chk(n >= PDL, "R2 low after long request", n, PDL);
    run_frame(16'h0001, 8'h0D, 0);

    // R10: second instance with a window shorter than one frame
    saw_ovr = 0;
    saw_val = 0;
    sd2 = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ovr2) saw_ovr = 1;
      if (valid2) saw_val = 1;
    end
    chk(saw_ovr, "R10 overrun pulse", int'(saw_ovr), 1);
    chk(!saw_val, "R10 no valid on abort", int'(saw_val), 0);
    chk(sclk2, "R10 sclk back high", int'(sclk2), 1);
    chk(!ovr, "R10 no overrun on timely reads", int'(ovr), 0);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule